// File: doc/BRIEF.md
# Tile Map Scanline Renderer

This block paints one screen of 240 by 240 pixels, one line at a time, from a single layer of 8x8 pixel tiles. The tiles are arranged on a 32 by 32 map that covers a 256 by 256 pixel area. For each screen pixel the block offsets the screen position by a scroll amount. It reads a tile number from the map and fetches the pixel byte of that tile from tile graphics memory. It then turns that byte into an RGB565 colour through a 256-entry palette and stores the colour in a 256-pixel line buffer.

A host fills the map, the tile graphics and the palette through three independent write ports. It supplies the horizontal and vertical scroll, a wrap enable and an inter-line idle count, and starts a frame with a one-cycle `start_frame` pulse. After each finished line the block pulses `line_done`, and after the last line of the frame it also pulses `frame_done`. The host drains the line buffer through a synchronous read port. It does this during the programmable idle gap that the renderer leaves before it starts the next line.

With wrap enabled, the map repeats in both directions. With wrap disabled, any pixel whose offset coordinate reaches 256 or more is drawn black and causes no memory reads.

Top module: `tile_line_renderer`

## Requirements
- R1: After reset `busy`, `line_done` and `frame_done` are low, and no line is rendered until `start_frame` is seen while idle.
- R2: With scroll zero and wrap on, the line buffer entry x of line y holds palette[T[i][y mod 8][x mod 8]]. Here i is the low TILE_IDX_W bits of map byte {y[7:3], x[7:3]}, and tile graphics byte address {i, row[2:0], col[2:0]} holds the palette index. Line buffer entries are written at their own x address.
- R3: The map column is screen x plus the horizontal scroll, and the map row is screen y plus the vertical scroll, both formed as 9-bit sums.
- R4: With wrap enabled, only the low 8 bits of each sum are used, so the map repeats past its right and bottom edges.
- R5: With wrap disabled, a pixel whose column or row sum is 256 or more is written as 16'h0000.
- R6: `line_done` is a one-cycle pulse. The first one of a frame comes SCREEN_W+4 cycles after the cycle in which `start_frame` is sampled, and each later one comes SCREEN_W+idle_cycles+4 cycles after the previous one.
- R7: `frame_done` pulses exactly once per frame, in the same cycle as the `line_done` of line SCREEN_H-1, and `busy` is low from that cycle on.
- R8: `start_frame` while idle makes `busy` high in the next cycle. While busy it is ignored, so line timing and line count are unchanged.
- R9: Scroll and wrap are captured when the frame starts. Changing them during a frame does not affect that frame's pixels.
- R10: `lb_rdata` presents line buffer entry `lb_raddr` one cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_we | input | 1 | Map write strobe |
| map_waddr | input | 10 | Map entry address {row, column} |
| map_wdata | input | 8 | Tile number to store |
| tile_we | input | 1 | Tile graphics write strobe |
| tile_waddr | input | TILE_IDX_W+6 | Tile graphics byte address {tile, row, column} |
| tile_wdata | input | 8 | Palette index to store |
| pal_we | input | 1 | Palette write strobe |
| pal_waddr | input | 8 | Palette entry address |
| pal_wdata | input | 16 | RGB565 colour |
| scroll_x | input | 8 | Horizontal scroll in pixels |
| scroll_y | input | 8 | Vertical scroll in pixels |
| wrap_en | input | 1 | 1: map repeats; 0: black past the map edge |
| idle_cycles | input | IDLE_W | Idle cycles left between lines |
| start_frame | input | 1 | Begin a frame at line 0 |
| lb_raddr | input | 8 | Line buffer read address |
| lb_rdata | output | 16 | Line buffer data, one cycle after the address |
| busy | output | 1 | A frame is being rendered |
| line_done | output | 1 | Line finished pulse |
| frame_done | output | 1 | Last line finished pulse |

## Verification
The bench builds the renderer with SCREEN_W=24, SCREEN_H=20, TILE_IDX_W=5 and IDLE_W=8. The small screen keeps each frame near fourteen hundred cycles, so several whole frames with different scroll and wrap settings fit easily. The map stays at its full 32 by 32 size, so scroll values near 255 push the 9-bit sums past 256 and reach both the wrap and the black cut-off paths. The 32-tile graphics store and map bytes with high bits set show that only the low tile-number bits select a tile.

// File: rtl/tlr_pkg.sv
package tlr_pkg;
    localparam int TILE_LOG2  = 3;
    localparam int MAP_LOG2   = 5;
    localparam int COORD_W    = TILE_LOG2 + MAP_LOG2;
    localparam int MAP_AW     = 2 * MAP_LOG2;
    localparam int PIX_W      = 8;
    localparam int RGB_W      = 16;
    localparam int PIPE_DEPTH = 3;

    typedef logic [RGB_W-1:0] rgb565_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DRAIN,
        ST_WAIT
    } seq_state_e;

    // Tag that travels alongside a pixel through the lookup pipeline
    typedef struct packed {
        logic                 valid;
        logic                 cut;
        logic [COORD_W-1:0]   x;
        logic [TILE_LOG2-1:0] fy;
        logic [TILE_LOG2-1:0] fx;
    } pix_tag_t;
endpackage

// File: rtl/tlr_ram.sv
module tlr_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/tlr_seq.sv
module tlr_seq
    import tlr_pkg::*;
#(
    parameter int SCREEN_W = 240,
    parameter int SCREEN_H = 240,
    parameter int IDLE_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_frame,
    input  logic [IDLE_W-1:0]  idle_cycles,
    input  logic [COORD_W-1:0] scroll_x,
    input  logic [COORD_W-1:0] scroll_y,
    input  logic               wrap_en,
    output logic               issue_valid,
    output logic [COORD_W-1:0] issue_x,
    output logic [COORD_W-1:0] issue_y,
    output logic [COORD_W-1:0] frame_sx,
    output logic [COORD_W-1:0] frame_sy,
    output logic               frame_wrap,
    output logic               busy,
    output logic               line_done,
    output logic               frame_done
);
    localparam logic [COORD_W-1:0] LAST_X = COORD_W'(SCREEN_W - 1);
    localparam logic [COORD_W-1:0] LAST_Y = COORD_W'(SCREEN_H - 1);
    localparam logic [IDLE_W-1:0]  DRAIN  = IDLE_W'(PIPE_DEPTH - 1);

    typedef struct packed {
        seq_state_e         st;
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
        logic [IDLE_W-1:0]  cnt;
        logic [COORD_W-1:0] sx;
        logic [COORD_W-1:0] sy;
        logic               wrap;
        logic               line_done;
        logic               frame_done;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d            = seq_q;
        seq_d.line_done  = 1'b0;
        seq_d.frame_done = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start_frame) begin
                    seq_d.st   = ST_RUN;
                    seq_d.x    = '0;
                    seq_d.y    = '0;
                    seq_d.sx   = scroll_x;
                    seq_d.sy   = scroll_y;
                    seq_d.wrap = wrap_en;
                end
            end
            ST_RUN: begin
                if (seq_q.x == LAST_X) begin
                    seq_d.st  = ST_DRAIN;
                    seq_d.cnt = DRAIN;
                end else begin
                    seq_d.x = seq_q.x + 1'b1;
                end
            end
            ST_DRAIN: begin
                if (seq_q.cnt == '0) begin
                    seq_d.line_done = 1'b1;
                    if (seq_q.y == LAST_Y) begin
                        seq_d.frame_done = 1'b1;
                        seq_d.st         = ST_IDLE;
                    end else begin
                        seq_d.st  = ST_WAIT;
                        seq_d.cnt = idle_cycles;
                        seq_d.y   = seq_q.y + 1'b1;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_WAIT: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st = ST_RUN;
                    seq_d.x  = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign issue_valid = (seq_q.st == ST_RUN);
    assign issue_x     = seq_q.x;
    assign issue_y     = seq_q.y;
    assign frame_sx    = seq_q.sx;
    assign frame_sy    = seq_q.sy;
    assign frame_wrap  = seq_q.wrap;
    assign busy        = (seq_q.st != ST_IDLE);
    assign line_done   = seq_q.line_done;
    assign frame_done  = seq_q.frame_done;
endmodule

// File: rtl/tlr_pipe.sv
module tlr_pipe
    import tlr_pkg::*;
#(
    parameter int TILE_IDX_W = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 issue_valid,
    input  logic [COORD_W-1:0]                   issue_x,
    input  logic [COORD_W-1:0]                   issue_y,
    input  logic [COORD_W-1:0]                   frame_sx,
    input  logic [COORD_W-1:0]                   frame_sy,
    input  logic                                 frame_wrap,
    output logic                                 map_re,
    output logic [MAP_AW-1:0]                    map_raddr,
    input  logic [PIX_W-1:0]                     map_rdata,
    output logic                                 tile_re,
    output logic [TILE_IDX_W+2*TILE_LOG2-1:0]    tile_raddr,
    input  logic [PIX_W-1:0]                     tile_rdata,
    output logic                                 pal_re,
    output logic [PIX_W-1:0]                     pal_raddr,
    input  rgb565_t                              pal_rdata,
    output logic                                 lb_we,
    output logic [COORD_W-1:0]                   lb_waddr,
    output rgb565_t                              lb_wdata
);
    typedef struct packed {
        pix_tag_t s1;
        pix_tag_t s2;
        pix_tag_t s3;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [COORD_W:0] map_col;
    logic [COORD_W:0] map_row;
    logic             cut0;

    // Only the low tile-number bits of a map byte select a tile
    generate
        if (TILE_IDX_W < PIX_W) begin : g_narrow_idx
            logic unused_hi;
            assign unused_hi = ^map_rdata[PIX_W-1:TILE_IDX_W];
        end
    endgenerate

    always_comb begin
        map_col = {1'b0, issue_x} + {1'b0, frame_sx};
        map_row = {1'b0, issue_y} + {1'b0, frame_sy};
        cut0    = !frame_wrap && (map_col[COORD_W] || map_row[COORD_W]);

        // Stage 0: map lookup
        map_re    = issue_valid && !cut0;
        map_raddr = {map_row[COORD_W-1:TILE_LOG2], map_col[COORD_W-1:TILE_LOG2]};

        pipe_d.s1.valid = issue_valid;
        pipe_d.s1.cut   = cut0;
        pipe_d.s1.x     = issue_x;
        pipe_d.s1.fy    = map_row[TILE_LOG2-1:0];
        pipe_d.s1.fx    = map_col[TILE_LOG2-1:0];

        // Stage 1: tile graphics lookup
        tile_re    = pipe_q.s1.valid && !pipe_q.s1.cut;
        tile_raddr = {map_rdata[TILE_IDX_W-1:0], pipe_q.s1.fy, pipe_q.s1.fx};
        pipe_d.s2  = pipe_q.s1;

        // Stage 2: palette lookup
        pal_re    = pipe_q.s2.valid && !pipe_q.s2.cut;
        pal_raddr = tile_rdata;
        pipe_d.s3 = pipe_q.s2;

        // Stage 3: line buffer write
        lb_we    = pipe_q.s3.valid;
        lb_waddr = pipe_q.s3.x;
        lb_wdata = pipe_q.s3.cut ? '0 : pal_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end
endmodule

// File: rtl/tile_line_renderer.sv
module tile_line_renderer
    import tlr_pkg::*;
#(
    parameter int SCREEN_W   = 240,
    parameter int SCREEN_H   = 240,
    parameter int TILE_IDX_W = 5,
    parameter int IDLE_W     = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              map_we,
    input  logic [9:0]                        map_waddr,
    input  logic [7:0]                        map_wdata,
    input  logic                              tile_we,
    input  logic [TILE_IDX_W+5:0]             tile_waddr,
    input  logic [7:0]                        tile_wdata,
    input  logic                              pal_we,
    input  logic [7:0]                        pal_waddr,
    input  logic [15:0]                       pal_wdata,
    input  logic [7:0]                        scroll_x,
    input  logic [7:0]                        scroll_y,
    input  logic                              wrap_en,
    input  logic [IDLE_W-1:0]                 idle_cycles,
    input  logic                              start_frame,
    input  logic [7:0]                        lb_raddr,
    output logic [15:0]                       lb_rdata,
    output logic                              busy,
    output logic                              line_done,
    output logic                              frame_done
);
    localparam int TILE_AW = TILE_IDX_W + 2 * TILE_LOG2;

    logic               issue_valid;
    logic [COORD_W-1:0] issue_x, issue_y;
    logic [COORD_W-1:0] frame_sx, frame_sy;
    logic               frame_wrap;

    logic               map_re, tile_re, pal_re, lb_we;
    logic [MAP_AW-1:0]  map_raddr;
    logic [TILE_AW-1:0] tile_raddr;
    logic [PIX_W-1:0]   pal_raddr;
    logic [PIX_W-1:0]   map_rdata, tile_rdata;
    rgb565_t            pal_rdata, lb_wdata;
    logic [COORD_W-1:0] lb_waddr;

    tlr_seq #(
        .SCREEN_W (SCREEN_W),
        .SCREEN_H (SCREEN_H),
        .IDLE_W   (IDLE_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_frame (start_frame),
        .idle_cycles (idle_cycles),
        .scroll_x    (scroll_x),
        .scroll_y    (scroll_y),
        .wrap_en     (wrap_en),
        .issue_valid (issue_valid),
        .issue_x     (issue_x),
        .issue_y     (issue_y),
        .frame_sx    (frame_sx),
        .frame_sy    (frame_sy),
        .frame_wrap  (frame_wrap),
        .busy        (busy),
        .line_done   (line_done),
        .frame_done  (frame_done)
    );

    tlr_pipe #(
        .TILE_IDX_W (TILE_IDX_W)
    ) u_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .issue_x     (issue_x),
        .issue_y     (issue_y),
        .frame_sx    (frame_sx),
        .frame_sy    (frame_sy),
        .frame_wrap  (frame_wrap),
        .map_re      (map_re),
        .map_raddr   (map_raddr),
        .map_rdata   (map_rdata),
        .tile_re     (tile_re),
        .tile_raddr  (tile_raddr),
        .tile_rdata  (tile_rdata),
        .pal_re      (pal_re),
        .pal_raddr   (pal_raddr),
        .pal_rdata   (pal_rdata),
        .lb_we       (lb_we),
        .lb_waddr    (lb_waddr),
        .lb_wdata    (lb_wdata)
    );

    tlr_ram #(.AW(MAP_AW), .DW(PIX_W)) u_map_ram (
        .clk (clk), .we (map_we), .waddr (map_waddr), .wdata (map_wdata),
        .re (map_re), .raddr (map_raddr), .rdata (map_rdata)
    );

    tlr_ram #(.AW(TILE_AW), .DW(PIX_W)) u_tile_ram (
        .clk (clk), .we (tile_we), .waddr (tile_waddr), .wdata (tile_wdata),
        .re (tile_re), .raddr (tile_raddr), .rdata (tile_rdata)
    );

    tlr_ram #(.AW(PIX_W), .DW(RGB_W)) u_pal_ram (
        .clk (clk), .we (pal_we), .waddr (pal_waddr), .wdata (pal_wdata),
        .re (pal_re), .raddr (pal_raddr), .rdata (pal_rdata)
    );

    tlr_ram #(.AW(COORD_W), .DW(RGB_W)) u_line_ram (
        .clk (clk), .we (lb_we), .waddr (lb_waddr), .wdata (lb_wdata),
        .re (1'b1), .raddr (lb_raddr), .rdata (lb_rdata)
    );
endmodule

// File: rtl/tlr_checker.sv
module tlr_checker (
    input logic clk,
    input logic rst_n,
    input logic start_frame,
    input logic busy,
    input logic line_done,
    input logic frame_done
);
    p_no_line_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !line_done);

    p_single_cycle_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done);

    p_frame_with_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> line_done);

    p_frame_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !busy);

    p_single_cycle_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    p_start_begins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_frame) |=> busy);
endmodule

bind tile_line_renderer tlr_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_frame (start_frame),
    .busy        (busy),
    .line_done   (line_done),
    .frame_done  (frame_done)
);

// File: tb/sim_tile_line_renderer.sv
module sim_tile_line_renderer;
    localparam int W  = 24;
    localparam int H  = 20;
    localparam int TI = 5;
    localparam int IW = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n;
    logic              map_we, tile_we, pal_we;
    logic [9:0]        map_waddr;
    logic [7:0]        map_wdata;
    logic [TI+5:0]     tile_waddr;
    logic [7:0]        tile_wdata;
    logic [7:0]        pal_waddr;
    logic [15:0]       pal_wdata;
    logic [7:0]        scroll_x, scroll_y;
    logic              wrap_en;
    logic [IW-1:0]     idle_cycles;
    logic              start_frame;
    logic [7:0]        lb_raddr;
    logic [15:0]       lb_rdata;
    logic              busy, line_done, frame_done;

    tile_line_renderer #(
        .SCREEN_W (W), .SCREEN_H (H), .TILE_IDX_W (TI), .IDLE_W (IW)
    ) u0 (
        .clk (clk), .rst_n (rst_n),
        .map_we (map_we), .map_waddr (map_waddr), .map_wdata (map_wdata),
        .tile_we (tile_we), .tile_waddr (tile_waddr), .tile_wdata (tile_wdata),
        .pal_we (pal_we), .pal_waddr (pal_waddr), .pal_wdata (pal_wdata),
        .scroll_x (scroll_x), .scroll_y (scroll_y), .wrap_en (wrap_en),
        .idle_cycles (idle_cycles), .start_frame (start_frame),
        .lb_raddr (lb_raddr), .lb_rdata (lb_rdata),
        .busy (busy), .line_done (line_done), .frame_done (frame_done)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [7:0]  map_m  [1024];
    logic [7:0]  tile_m [1 << (TI + 6)];
    logic [15:0] pal_m  [256];

    typedef struct {
        int          line;
        int          x;
        logic [15:0] v;
        string       req;
    } item_t;
    item_t sbq[$];

    int start_cyc, last_ld, cur_idle, line_idx, frames_done;
    bit first_line;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_pix(input int x, input int y,
                                            input logic [7:0] sx, input logic [7:0] sy,
                                            input bit wr);
        logic [8:0] mc, mr;
        logic [7:0] idx, b;
        mc = 9'(x) + 9'(sx);
        mr = 9'(y) + 9'(sy);
        if (!wr && (mc[8] || mr[8])) return 16'h0000;
        idx = map_m[{mr[7:3], mc[7:3]}];
        b   = tile_m[{idx[TI-1:0], mr[2:0], mc[2:0]}];
        return pal_m[b];
    endfunction

    // Monitor: timing of strobes and line buffer contents against the scoreboard
    initial begin
        line_idx = 0; frames_done = 0; first_line = 1; lb_raddr = '0;
        forever begin
            @(negedge clk);
            if (rst_n && line_done) begin
                if (first_line)
                    chk(cyc - start_cyc == W + 4, "R6", "first line_done delay",
                        cyc - start_cyc, W + 4);
                else
                    chk(cyc - last_ld == W + cur_idle + 4, "R6", "line_done period",
                        cyc - last_ld, W + cur_idle + 4);
                last_ld = cyc;
                first_line = 0;
                chk(frame_done == (line_idx == H - 1), "R7", "frame_done with line",
                    frame_done, line_idx == H - 1);
                chk(busy == (line_idx != H - 1), "R7", "busy at line_done",
                    busy, line_idx != H - 1);
                for (int x = 0; x < W; x++) begin
                    lb_raddr = 8'(x);
                    @(negedge clk);
                    if (sbq.size() == 0) begin
                        chk(0, "R10", "scoreboard empty", 0, 1);
                    end else begin
                        item_t it;
                        it = sbq.pop_front();
                        checks++;
                        if (it.line != line_idx || it.x != x || lb_rdata !== it.v) begin
                            errors++;
                            $display("FAIL %s line %0d x %0d actual %h expected %h",
                                     it.req, line_idx, x, lb_rdata, it.v);
                        end
                    end
                end
                if (line_idx == H - 1) begin
                    line_idx = 0;
                    first_line = 1;
                    frames_done++;
                end else begin
                    line_idx++;
                end
            end
        end
    end

    task automatic run_frame(input logic [7:0] sx, input logic [7:0] sy, input bit wr,
                             input int idle, input string req, input bit disturb);
        int target;
        @(negedge clk);
        scroll_x = sx; scroll_y = sy; wrap_en = wr;
        idle_cycles = IW'(idle); cur_idle = idle;
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++)
                sbq.push_back('{y, x, exp_pix(x, y, sx, sy, wr), req});
        target = frames_done + 1;
        start_frame = 1'b1;
        start_cyc = cyc;
        first_line = 1;
        @(negedge clk);
        start_frame = 1'b0;
        chk(busy == 1'b1, "R8", "busy after start", busy, 1);
        if (disturb) begin
            // R9: new scroll/wrap mid-frame must not alter this frame
            // R8: a second start while busy must not restart the frame
            repeat (W * 3) @(negedge clk);
            scroll_x = ~sx; scroll_y = sy + 8'd9; wrap_en = !wr;
            start_frame = 1'b1;
            @(negedge clk);
            start_frame = 1'b0;
        end
        wait (frames_done == target);
        repeat (W + 10) @(negedge clk);
        chk(!busy && !line_done, "R8", "quiet after frame", busy, 0);
    endtask

    task automatic host_fill();
        for (int i = 0; i < 1024; i++) begin
            @(negedge clk);
            map_m[i] = 8'(i * 7 + 3);
            map_we = 1'b1; map_waddr = 10'(i); map_wdata = map_m[i];
        end
        @(negedge clk); map_we = 1'b0;
        for (int i = 0; i < (1 << (TI + 6)); i++) begin
            @(negedge clk);
            tile_m[i] = 8'(i * 13 + 5);
            tile_we = 1'b1; tile_waddr = (TI + 6)'(i); tile_wdata = tile_m[i];
        end
        @(negedge clk); tile_we = 1'b0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            pal_m[i] = {8'(i), ~8'(i)};
            pal_we = 1'b1; pal_waddr = 8'(i); pal_wdata = pal_m[i];
        end
        @(negedge clk); pal_we = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog expired actual %0d expected below %0d", cyc, 150000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit quiet;
        rst_n = 1'b0; map_we = 0; tile_we = 0; pal_we = 0;
        map_waddr = '0; map_wdata = '0; tile_waddr = '0; tile_wdata = '0;
        pal_waddr = '0; pal_wdata = '0; scroll_x = '0; scroll_y = '0;
        wrap_en = 1'b1; idle_cycles = '0; start_frame = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !line_done && !frame_done, "R1", "idle after reset",
            {busy, line_done, frame_done}, 0);
        host_fill();
        quiet = 1;
        repeat (50) begin
            @(negedge clk);
            if (line_done || busy) quiet = 0;
        end
        chk(quiet, "R1", "no activity without start", !quiet, 0);

        run_frame(8'd0,   8'd0,   1'b1, 40, "R2 R10", 1'b0);
        run_frame(8'd5,   8'd3,   1'b1, 37, "R3 R9",  1'b1);
        run_frame(8'd240, 8'd250, 1'b1, 30, "R4",     1'b0);
        run_frame(8'd240, 8'd250, 1'b0, 30, "R5",     1'b0);
        run_frame(8'd250, 8'd0,   1'b0, 26, "R5 R3",  1'b0);

        chk(sbq.size() == 0, "R7", "all lines delivered", sbq.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule